// File: doc/BRIEF.md
# Prioritized Loadable Program Counter

This block holds the address of the next instruction for a sequencer. It is a 16-bit register with three control inputs that are resolved by strict priority on every rising clock edge. A clear request forces the count to zero. A load request copies the data input into the count. A step request advances the count by one. With no request the count is held.

The count is driven on the output continuously. A consumer reads it directly with no strobe. It changes only at rising clock edges. Advancing past the largest value wraps to zero, and no flag marks the wrap. The clear input is synchronous and also serves as the power-on initialisation: the first edge that samples clear high sets the count to zero.

Top module: `prog_counter`

## Requirements
- R1: When clear_i is 1 at a rising edge, count_o is 0x0000 after that edge, whatever load_i, step_i and data_i are.
- R2: When clear_i is 0 and load_i is 1 at a rising edge, count_o equals the data_i value sampled at that edge, whatever step_i is.
- R3: When clear_i and load_i are 0 and step_i is 1 at a rising edge, count_o becomes its previous value plus one.
- R4: When clear_i, load_i and step_i are all 0 at a rising edge, count_o keeps its value, and data_i has no effect on it.
- R5: A step from 0xFFFF gives 0x0000, and a later step from there gives 0x0001.
- R6: count_o is 16 bits wide and needs no read strobe. It is stable between rising edges even while the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| clear_i | input | 1 | Synchronous clear, highest priority |
| load_i | input | 1 | Parallel load of data_i, second priority |
| step_i | input | 1 | Advance by one, third priority |
| data_i | input | 16 | Value taken by a load |
| count_o | output | 16 | Current count, always valid |

## Verification
A wrong priority decision or a wrong next value appears on count_o one edge after the controls that caused it. No stage sits between the register and the port to hide or delay it. A wrong carry in the incrementer shows up only on steps that cross a carry boundary, and the wrap from 0xFFFF is the worst case. For that reason the stimulus loads values just below such boundaries before stepping. A hold that leaks data_i into the register shows at the next sample, because data_i is kept changing during idle cycles.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

    localparam int PCNT_W = 16;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } pcnt_action_e;

endpackage

// File: rtl/pcnt_arbiter.sv
module pcnt_arbiter
    import pcnt_pkg::*;
(
    input  logic         clear_i,
    input  logic         load_i,
    input  logic         step_i,
    output pcnt_action_e action_o
);

    logic [3:0] grant;

    always_comb begin
        grant = 4'b0000;
        if (clear_i)     grant[ACT_CLEAR] = 1'b1;
        else if (load_i) grant[ACT_LOAD]  = 1'b1;
        else if (step_i) grant[ACT_STEP]  = 1'b1;
        else             grant[ACT_HOLD]  = 1'b1;
    end

    always_comb begin
        action_o = ACT_HOLD;
        for (int i = 0; i < 4; i++) begin
            if (grant[i]) action_o = pcnt_action_e'(i);
        end
    end

endmodule

// File: rtl/pcnt_incr.sv
module pcnt_incr #(
    parameter int  W      = 16,
    parameter bit  RIPPLE = 1'b1
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] sum_o
);

    generate
        if (RIPPLE) begin : g_ripple
            logic [W:0] carry;
            assign carry[0] = 1'b1;
            for (genvar b = 0; b < W; b++) begin : g_bit
                assign sum_o[b]    = a_i[b] ^ carry[b];
                assign carry[b+1]  = a_i[b] & carry[b];
            end
        end else begin : g_adder
            assign sum_o = a_i + W'(1);
        end
    endgenerate

endmodule

// File: rtl/prog_counter.sv
module prog_counter
    import pcnt_pkg::*;
#(
    parameter int W      = PCNT_W,
    parameter bit RIPPLE = 1'b1
) (
    input  logic         clk_i,
    input  logic         clear_i,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [15:0]  data_i,
    output logic [15:0]  count_o
);

    localparam logic [W-1:0] ZERO = '0;

    typedef struct packed {
        logic [W-1:0] count;
        logic         armed;
    } pcnt_state_t;

    pcnt_state_t  st_d, st_q;
    pcnt_action_e act;
    logic [W-1:0] next_up;

    pcnt_arbiter u_arb (
        .clear_i  (clear_i),
        .load_i   (load_i),
        .step_i   (step_i),
        .action_o (act)
    );

    pcnt_incr #(.W(W), .RIPPLE(RIPPLE)) u_inc (
        .a_i   (st_q.count),
        .sum_o (next_up)
    );

    always_comb begin
        st_d = st_q;
        case (act)
            ACT_CLEAR: begin
                st_d.count = ZERO;
                st_d.armed = 1'b1;
            end
            ACT_LOAD:  st_d.count = W'(data_i);
            ACT_STEP:  st_d.count = next_up;
            default:   st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign count_o = 16'(st_q.count);

    assert_clear_zero_R1: assert property (@(posedge clk_i) disable iff (!st_q.armed)
        clear_i |=> (count_o == 16'h0000));

    assert_load_value_R2: assert property (@(posedge clk_i) disable iff (!st_q.armed)
        (!clear_i && load_i) |=> (count_o == $past(data_i)));

    assert_step_plus_one_R3: assert property (@(posedge clk_i) disable iff (!st_q.armed)
        (!clear_i && !load_i && step_i) |=> (count_o == 16'($past(count_o) + 16'd1)));

    assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!st_q.armed)
        (!clear_i && !load_i && !step_i) |=> $stable(count_o));

    assert_wrap_zero_R5: assert property (@(posedge clk_i) disable iff (!st_q.armed)
        (!clear_i && !load_i && step_i && count_o == 16'hFFFF) |=> (count_o == 16'h0000));

endmodule

// File: tb/sim_prog_counter.sv
module sim_prog_counter;

    logic        clk = 1'b0;
    logic        clear_i = 1'b0;
    logic        load_i = 1'b0;
    logic        step_i = 1'b0;
    logic [15:0] data_i = 16'h0000;
    logic [15:0] count_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] model = 16'h0000;

    always #4 clk = ~clk;

    prog_counter u0 (
        .clk_i   (clk),
        .clear_i (clear_i),
        .load_i  (load_i),
        .step_i  (step_i),
        .data_i  (data_i),
        .count_o (count_o)
    );

    function automatic logic [15:0] next_of(input logic [15:0] cur, input logic c,
                                           input logic l, input logic s, input logic [15:0] d);
        if (c)      return 16'h0000;
        else if (l) return d;
        else if (s) return cur + 16'd1;
        else        return cur;
    endfunction

    function automatic string tag_of(input logic c, input logic l, input logic s);
        if (c)      return "R1";
        else if (l) return "R2";
        else if (s) return "R3";
        else        return "R4";
    endfunction

    task automatic check(input logic [15:0] exp, input string tag);
        n_chk++;
        if (count_o !== exp) begin
            n_bad++;
            $display("FAIL %s: count_o=%h expected=%h", tag, count_o, exp);
        end
    endtask

    task automatic cycle(input logic c, input logic l, input logic s, input logic [15:0] d,
                         input string tag);
        @(negedge clk);
        clear_i = c; load_i = l; step_i = s; data_i = d;
        model = next_of(model, c, l, s, d);
        @(posedge clk);
        #1;
        check(model, tag);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: count_o=%h expected=%h", count_o, model);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        cycle(1'b1, 1'b0, 1'b0, 16'h0000, "R1");
        // R6: stable between edges while inputs wiggle
        @(negedge clk);
        clear_i = 1'b0; load_i = 1'b0; step_i = 1'b0; data_i = 16'hA5A5;
        #1; check(model, "R6");
        data_i = 16'h5A5A; load_i = 1'b1; #1; check(model, "R6");
        load_i = 1'b0;
        @(posedge clk); #1; check(model, "R4");
        // all eight control combinations from a known value
        for (int k = 0; k < 8; k++) begin
            cycle(1'b0, 1'b1, 1'b0, 16'h1230 + 16'(k), "R2");
            cycle(k[2], k[1], k[0], 16'hBEE0 + 16'(k),
                  tag_of(k[2], k[1], k[0]));
        end
        // R4: idle with data changing
        for (int k = 0; k < 4; k++) cycle(1'b0, 1'b0, 1'b0, 16'(k * 16'h1111), "R4");
        // R5: wrap
        cycle(1'b0, 1'b1, 1'b0, 16'hFFFE, "R2");
        cycle(1'b0, 1'b0, 1'b1, 16'h0000, "R3");
        cycle(1'b0, 1'b0, 1'b1, 16'h1234, "R5");
        cycle(1'b0, 1'b0, 1'b1, 16'h0000, "R5");
        // carry boundaries
        cycle(1'b0, 1'b1, 1'b0, 16'h00FF, "R2");
        cycle(1'b0, 1'b0, 1'b1, 16'h0000, "R3");
        cycle(1'b0, 1'b1, 1'b1, 16'h7FFF, "R2");
        cycle(1'b0, 1'b0, 1'b1, 16'h0000, "R3");
        // random mix, clear kept rare
        for (int k = 0; k < 3000; k++) begin
            logic c, l, s;
            logic [15:0] d;
            c = ($urandom_range(0, 15) == 0);
            l = ($urandom_range(0, 3) == 0);
            s = ($urandom_range(0, 1) == 1);
            d = ($urandom_range(0, 3) == 0) ? 16'hFFFF - 16'($urandom_range(0, 3))
                                             : 16'($urandom);
            cycle(c, l, s, d, tag_of(c, l, s));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule